// File: doc/BRIEF.md
# Cross-Lane Ring Transfer Network

This block moves data words between virtual processors (VPs) that form a one-way ring. The VPs are spread over four lanes by index, so VP n sits in lane n mod 4. A word sent by VP n is always received by VP n+1, which normally lives in the next lane. Each lane has a link FIFO to its right-hand neighbour. Each lane has one send port and one receive port, and both use valid/ready handshakes. A lane's successive sends and receives belong to its VPs in rising index order, and the sequence starts again after the last VP of the current vector length.

The two ends of the ring meet in a small boundary queue. A word sent by the last VP (index vl-1) goes into this queue instead of a link. VP 0 takes its incoming word from the same queue. The controller can load a seed word into the queue before a block runs, and it can remove the final word afterwards. If the controller removes nothing, the word leaving the last VP becomes VP 0's input on the next pass. Words are delivered as soon as the producer supplies them. A receiver whose word is not yet there sees valid low and waits.

Top module: `ring_xfer_net`

## Requirements
- R1: After reset every link FIFO and the boundary queue are empty, and both error flags are low. With vl_i at 4 or more, all four `tx_ready_o` bits are high and all `rx_valid_o` bits are low.
- R2: Lane L's k-th send and k-th receive in a pass belong to VP L+4k. A word sent by VP n with n < vl-1 is presented only at the receive port of lane (n+1) mod 4, as the input of VP n+1. There is no path from lane L+1 back to lane L.
- R3: Each link holds up to 2 words. When a link is full, the sending lane's `tx_ready_o` is low unless that lane's current VP is the last one.
- R4: A receiving lane's `rx_valid_o` stays low until its predecessor's word has arrived, so a consumer simply stalls.
- R5: A send from VP vl-1 is written into the boundary queue. That lane's `tx_ready_o` is low while the queue is full. With vl_i = 1, VP 0 is both the first and the last VP.
- R6: VP 0's receive (lane 0, first VP of a pass) takes the oldest word in the boundary queue. Its `rx_valid_o` is low while the queue is empty or while `ctl_pop_i` is high, because the controller has priority.
- R7: `ctl_push_ok_o` is high in the same cycle when a controller push is accepted. A push is accepted only if the queue is not full and no last-VP write happens in that cycle. A refused push leaves the queue unchanged and sets `push_err_o` for exactly the following cycle.
- R8: A controller pop on a non-empty queue shows `ctl_pop_ok_o` high and the oldest word on `ctl_pop_data_o` in the same cycle. A pop on an empty queue sets `pop_err_o` for the following cycle.
- R9: The boundary queue is 4 words deep and first-in first-out.
- R10: A lane whose first VP index is at or beyond vl_i holds no VP. Its `tx_ready_o` and `rx_valid_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| vl_i | input | 8 | Vector length, 1..128 |
| tx_valid_i | input | 4 | Per-lane send valid |
| tx_ready_o | output | 4 | Per-lane send ready |
| tx_data_i | input | 4 x 32 | Per-lane send word |
| rx_valid_o | output | 4 | Per-lane receive valid |
| rx_ready_i | input | 4 | Per-lane receive ready |
| rx_data_o | output | 4 x 32 | Per-lane receive word |
| ctl_push_i | input | 1 | Controller push request |
| ctl_push_data_i | input | 32 | Controller push word |
| ctl_push_ok_o | output | 1 | Push accepted this cycle |
| ctl_pop_i | input | 1 | Controller pop request |
| ctl_pop_ok_o | output | 1 | Pop accepted this cycle |
| ctl_pop_data_o | output | 32 | Oldest queue word |
| push_err_o | output | 1 | Refused push in previous cycle |
| pop_err_o | output | 1 | Refused pop in previous cycle |

## Verification
The assertions check the following on every cycle:
- no FIFO is ever written while full or read while empty;
- lanes without a VP stay silent;
- VP 0 yields to a controller pop;
- each refused controller request raises its flag one cycle later;
- a cursor only advances while its lane holds a VP.

The bench scenarios cover what needs a sequence of events:
- the lane-to-lane mapping across a wrapping pass;
- strict delivery order through a link that fills;
- the seed and result path through the boundary queue;
- the vl = 1 self-loop;
- the order of the boundary queue when lane and controller traffic mix.

// File: rtl/ring_pkg.sv
package ring_pkg;

    localparam int RING_LANES_DEF = 4;
    localparam int RING_WORD_W    = 32;
    localparam int RING_MAX_VP    = 128;
    localparam int RING_LINK_DEP  = 2;
    localparam int RING_BQ_DEP    = 4;

    // where a lane's pending send is steered
    typedef enum logic [1:0] {
        RT_NONE  = 2'd0,
        RT_LINK  = 2'd1,
        RT_QUEUE = 2'd2
    } route_e;

    // which ring edge a cursor reports
    typedef enum logic {
        CUR_SEND = 1'b0,
        CUR_RECV = 1'b1
    } cursor_role_e;

    function automatic int nbr_lane(input int lane, input int lanes);
        return (lane + 1) % lanes;
    endfunction

endpackage

// File: rtl/ring_fifo.sv
module ring_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 2
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          push_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          pop_i,
    output logic [DW-1:0] rdata_o,
    output logic          full_o,
    output logic          empty_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full_o  = (count == CW'(DEPTH));
    assign empty_o = (count == '0);
    assign rdata_o = mem[rd_ptr];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_i) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop_i) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({push_i, pop_i})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (push_i) begin
            mem[wr_ptr] <= wdata_i;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        !(push_i && full_o)); // R3, R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        !(pop_i && empty_o)); // R9

endmodule

// File: rtl/ring_vp_cursor.sv
module ring_vp_cursor
    import ring_pkg::*;
#(
    parameter int           LANES = 4,
    parameter int           LANE  = 0,
    parameter int           IDX_W = 7,
    parameter cursor_role_e ROLE  = CUR_SEND
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         adv_i,
    input  logic [IDX_W:0] vl_i,
    output logic         active_o,
    output logic         edge_o
);
    localparam int VW = IDX_W + 1;

    logic [IDX_W-1:0] idx;
    logic [VW:0]      nxt;

    assign nxt      = {2'b00, idx} + (VW + 1)'(LANES);
    assign active_o = ({1'b0, idx} < vl_i);

    generate
        if (ROLE == CUR_SEND) begin : g_last
            assign edge_o = ({1'b0, idx} == (vl_i - VW'(1)));
        end else begin : g_first
            assign edge_o = (idx == '0);
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            idx <= IDX_W'(LANE);
        end else if (adv_i) begin
            if (nxt >= {1'b0, vl_i}) begin
                idx <= IDX_W'(LANE);
            end else begin
                idx <= nxt[IDX_W-1:0];
            end
        end
    end

    AST_CURSOR_LIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        adv_i |-> active_o); // R10

endmodule

// File: rtl/ring_xfer_net.sv
module ring_xfer_net
    import ring_pkg::*;
#(
    parameter int LANES     = RING_LANES_DEF,
    parameter int DW        = RING_WORD_W,
    parameter int MAX_VP    = RING_MAX_VP,
    parameter int LINK_DEP  = RING_LINK_DEP,
    parameter int BQ_DEP    = RING_BQ_DEP
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic [$clog2(MAX_VP):0]       vl_i,
    input  logic [LANES-1:0]              tx_valid_i,
    output logic [LANES-1:0]              tx_ready_o,
    input  logic [LANES-1:0][DW-1:0]      tx_data_i,
    output logic [LANES-1:0]              rx_valid_o,
    input  logic [LANES-1:0]              rx_ready_i,
    output logic [LANES-1:0][DW-1:0]      rx_data_o,
    input  logic                          ctl_push_i,
    input  logic [DW-1:0]                 ctl_push_data_i,
    output logic                          ctl_push_ok_o,
    input  logic                          ctl_pop_i,
    output logic                          ctl_pop_ok_o,
    output logic [DW-1:0]                 ctl_pop_data_o,
    output logic                          push_err_o,
    output logic                          pop_err_o
);
    localparam int IDX_W = $clog2(MAX_VP);

    // per-lane state
    logic [LANES-1:0]          tx_act, tx_last, tx_fire;
    logic [LANES-1:0]          rx_act, rx_first, rx_fire;
    route_e                    tx_route [LANES];
    logic [LANES-1:0]          link_push, link_pop, link_full, link_empty;
    logic [LANES-1:0][DW-1:0]  link_q;
    logic [LANES-1:0]          to_bq, from_bq;

    // boundary queue
    logic          bq_push, bq_pop, bq_full, bq_empty, lane_wr;
    logic [DW-1:0] bq_wdata, bq_q, lane_word;

    generate
        for (genvar L = 0; L < LANES; L++) begin : g_lane
            localparam int NXT = nbr_lane(L, LANES);
            localparam int PRV = (L + LANES - 1) % LANES;

            ring_vp_cursor #(
                .LANES(LANES), .LANE(L), .IDX_W(IDX_W), .ROLE(CUR_SEND)
            ) i_tx_cur (
                .clk_i(clk_i), .rst_i(rst_i), .adv_i(tx_fire[L]),
                .vl_i(vl_i), .active_o(tx_act[L]), .edge_o(tx_last[L])
            );

            ring_vp_cursor #(
                .LANES(LANES), .LANE(L), .IDX_W(IDX_W), .ROLE(CUR_RECV)
            ) i_rx_cur (
                .clk_i(clk_i), .rst_i(rst_i), .adv_i(rx_fire[L]),
                .vl_i(vl_i), .active_o(rx_act[L]), .edge_o(rx_first[L])
            );

            ring_fifo #(.DW(DW), .DEPTH(LINK_DEP)) i_link (
                .clk_i(clk_i), .rst_i(rst_i),
                .push_i(link_push[L]), .wdata_i(tx_data_i[L]),
                .pop_i(link_pop[L]), .rdata_o(link_q[L]),
                .full_o(link_full[L]), .empty_o(link_empty[L])
            );

            // send side steering
            always_comb begin
                if (!tx_act[L])      tx_route[L] = RT_NONE;
                else if (tx_last[L]) tx_route[L] = RT_QUEUE;
                else                 tx_route[L] = RT_LINK;
            end

            always_comb begin
                case (tx_route[L])
                    RT_LINK:  tx_ready_o[L] = !link_full[L];
                    RT_QUEUE: tx_ready_o[L] = !bq_full;
                    default:  tx_ready_o[L] = 1'b0;
                endcase
            end

            assign tx_fire[L]   = tx_valid_i[L] && tx_ready_o[L];
            assign link_push[L] = tx_fire[L] && (tx_route[L] == RT_LINK);
            assign to_bq[L]     = tx_fire[L] && (tx_route[L] == RT_QUEUE);

            // receive side: first VP reads the boundary queue, others the link behind
            assign rx_valid_o[L] = rx_act[L] &&
                                   (rx_first[L] ? (!bq_empty && !ctl_pop_i)
                                                : !link_empty[PRV]);
            assign rx_data_o[L]  = rx_first[L] ? bq_q : link_q[PRV];
            assign rx_fire[L]    = rx_valid_o[L] && rx_ready_i[L];
            assign from_bq[L]    = rx_fire[L] && rx_first[L];

            // this lane's link is drained by the neighbour it feeds
            assign link_pop[L]   = rx_fire[NXT] && !rx_first[NXT];

            AST_IDLE_LANE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
                (vl_i <= ($clog2(MAX_VP)+1)'(L)) |-> (!tx_ready_o[L] && !rx_valid_o[L])); // R10
        end
    endgenerate

    // at most one lane holds the last VP; pick its word
    always_comb begin
        lane_word = '0;
        for (int l = 0; l < LANES; l++) begin
            if (to_bq[l]) lane_word = tx_data_i[l];
        end
    end

    assign lane_wr        = |to_bq;
    assign ctl_push_ok_o  = ctl_push_i && !bq_full && !lane_wr;
    assign bq_push        = lane_wr || ctl_push_ok_o;
    assign bq_wdata       = lane_wr ? lane_word : ctl_push_data_i;
    assign ctl_pop_ok_o   = ctl_pop_i && !bq_empty;
    assign bq_pop         = ctl_pop_ok_o || (|from_bq);
    assign ctl_pop_data_o = bq_q;

    ring_fifo #(.DW(DW), .DEPTH(BQ_DEP)) i_bq (
        .clk_i(clk_i), .rst_i(rst_i),
        .push_i(bq_push), .wdata_i(bq_wdata),
        .pop_i(bq_pop), .rdata_o(bq_q),
        .full_o(bq_full), .empty_o(bq_empty)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            push_err_o <= 1'b0;
            pop_err_o  <= 1'b0;
        end else begin
            push_err_o <= ctl_push_i && !ctl_push_ok_o;
            pop_err_o  <= ctl_pop_i && !ctl_pop_ok_o;
        end
    end

    AST_PUSH_REFUSED_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctl_push_i && !ctl_push_ok_o) |=> push_err_o); // R7
    AST_POP_REFUSED_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctl_pop_i && !ctl_pop_ok_o) |=> pop_err_o); // R8
    AST_VP0_YIELDS: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctl_pop_i && rx_first[0]) |-> !rx_valid_o[0]); // R6
    AST_ONE_QUEUE_WRITER: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(to_bq) <= 1); // R5

endmodule

// File: tb/test_ring_xfer_net.sv
`timescale 1ns/1ps
module test_ring_xfer_net;

    logic             clk = 1'b0;
    logic             rst;
    logic [7:0]       vl;
    logic [3:0]       tx_valid, tx_ready, rx_valid, rx_ready;
    logic [3:0][31:0] tx_data, rx_data;
    logic             c_push, c_push_ok, c_pop, c_pop_ok, push_err, pop_err;
    logic [31:0]      c_push_data, c_pop_data;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    logic [31:0] sb [$];

    always #2.5 clk = ~clk;

    ring_xfer_net i_ring_xfer_net (
        .clk_i(clk), .rst_i(rst), .vl_i(vl),
        .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data),
        .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_data_o(rx_data),
        .ctl_push_i(c_push), .ctl_push_data_i(c_push_data), .ctl_push_ok_o(c_push_ok),
        .ctl_pop_i(c_pop), .ctl_pop_ok_o(c_pop_ok), .ctl_pop_data_o(c_pop_data),
        .push_err_o(push_err), .pop_err_o(pop_err)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compares every receive handshake with the scoreboard head
    always begin
        @(negedge clk);
        #2;
        for (int l = 0; l < 4; l++) begin
            if (rx_valid[l] && rx_ready[l]) begin
                if (sb.size() == 0) begin
                    vectors++; fails++;
                    $display("FAIL R2 lane %0d actual=%h expected=<none>", l, rx_data[l]);
                end else begin
                    chk(rx_data[l], sb.pop_front(), "R2 ring delivery");
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // driver: send one word; exp_rx queues the word for the scoreboard
    task automatic do_send(input int lane, input logic [31:0] d, input bit exp_rx, input string req);
        int w = 0;
        @(negedge clk);
        tx_valid[lane] = 1'b1;
        tx_data[lane]  = d;
        #1;
        while (!tx_ready[lane] && w < 20) begin
            @(negedge clk); #1; w++;
        end
        chk(32'(tx_ready[lane]), 32'd1, req);
        if (tx_ready[lane]) begin
            if (exp_rx) sb.push_back(d);
            @(posedge clk);
        end
        @(negedge clk);
        tx_valid[lane] = 1'b0;
    endtask

    task automatic do_recv(input int lane, input string req);
        int w = 0;
        @(negedge clk);
        rx_ready[lane] = 1'b1;
        #1;
        while (!rx_valid[lane] && w < 20) begin
            @(negedge clk); #1; w++;
        end
        chk(32'(rx_valid[lane]), 32'd1, req);
        if (rx_valid[lane]) @(posedge clk);
        @(negedge clk);
        rx_ready[lane] = 1'b0;
    endtask

    task automatic do_push(input logic [31:0] d, input bit exp_ok, input string req);
        @(negedge clk);
        c_push = 1'b1; c_push_data = d;
        #1;
        chk(32'(c_push_ok), 32'(exp_ok), req);
        @(posedge clk);
        @(negedge clk);
        c_push = 1'b0;
        #1;
        chk(32'(push_err), 32'(!exp_ok), req);
    endtask

    task automatic do_pop(input logic [31:0] d, input bit exp_ok, input string req);
        @(negedge clk);
        c_pop = 1'b1;
        #1;
        chk(32'(c_pop_ok), 32'(exp_ok), req);
        if (exp_ok) chk(c_pop_data, d, req);
        @(posedge clk);
        @(negedge clk);
        c_pop = 1'b0;
        #1;
        chk(32'(pop_err), 32'(!exp_ok), req);
    endtask

    initial begin
        rst = 1'b1; vl = 8'd6;
        tx_valid = '0; tx_data = '0; rx_ready = '0;
        c_push = 1'b0; c_pop = 1'b0; c_push_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(32'(tx_ready), 32'hF, "R1 tx_ready after reset");
        chk(32'(rx_valid), 32'h0, "R1 rx_valid after reset");
        chk(32'({push_err, pop_err}), 32'h0, "R1 error flags after reset");

        // seed into VP0 (R6), then a full pass with vl=6 (R2, R5)
        do_push(32'hA0, 1'b1, "R7 seed push");
        sb.push_back(32'hA0);
        do_recv(0, "R6 VP0 takes seed");
        for (int n = 0; n < 6; n++) begin
            do_send(n % 4, 32'hD0 + 32'(n), n < 5, "R2 pass send");
        end
        for (int n = 1; n < 6; n++) begin
            do_recv(n % 4, "R2 pass receive");
        end
        do_pop(32'hD5, 1'b1, "R5 last VP result in queue");

        // R3: link fills after two words; R4: stall; strict order
        do_send(0, 32'hE0, 1'b1, "R3 link first word");
        do_send(0, 32'hE4, 1'b1, "R3 link second word");
        @(negedge clk);
        tx_valid[0] = 1'b1; tx_data[0] = 32'hEE;
        #1;
        chk(32'(tx_ready[0]), 32'd0, "R3 full link blocks sender");
        chk(32'(rx_valid[2]), 32'd0, "R4 receiver stalls on empty link");
        chk(32'(rx_valid[0]), 32'd0, "R6 VP0 stalls on empty queue");
        @(negedge clk);
        tx_valid[0] = 1'b0;
        do_recv(1, "R2 order first");
        do_recv(1, "R2 order second");

        // R9 depth and order, R7/R8 refusals
        for (int i = 0; i < 4; i++) do_push(32'hF0 + 32'(i), 1'b1, "R9 fill queue");
        do_push(32'hFF, 1'b0, "R7 push on full refused");
        for (int i = 0; i < 4; i++) do_pop(32'hF0 + 32'(i), 1'b1, "R9 fifo order");
        do_pop(32'h0, 1'b0, "R8 pop on empty refused");

        // vl=2: idle lanes, full queue blocks last VP, controller priority
        for (int i = 0; i < 4; i++) do_push(32'hC0 + 32'(i), 1'b1, "R9 refill");
        @(negedge clk);
        vl = 8'd2;
        #1;
        chk(32'(tx_ready[3:2]), 32'd0, "R10 idle lanes tx_ready");
        chk(32'(rx_valid[3:2]), 32'd0, "R10 idle lanes rx_valid");
        chk(32'(tx_ready[1]), 32'd0, "R5 full queue blocks last VP");
        @(negedge clk);
        c_pop = 1'b1; rx_ready[0] = 1'b1;
        #1;
        chk(32'(rx_valid[0]), 32'd0, "R6 VP0 yields to controller pop");
        chk(c_pop_data, 32'hC0, "R8 pop data under contention");
        @(posedge clk);
        @(negedge clk);
        c_pop = 1'b0; rx_ready[0] = 1'b0;
        do_send(1, 32'hB1, 1'b0, "R5 last VP writes queue");
        for (int i = 1; i < 4; i++) do_pop(32'hC0 + 32'(i), 1'b1, "R9 order kept");
        do_pop(32'hB1, 1'b1, "R5 last VP word behind controller words");

        // vl=1: VP0 feeds itself through the queue
        @(negedge clk);
        vl = 8'd1;
        do_send(0, 32'h77, 1'b0, "R5 single VP send");
        sb.push_back(32'h77);
        do_recv(0, "R6 single VP receives own word");

        repeat (3) @(negedge clk);
        chk(32'(sb.size()), 32'd0, "R2 scoreboard drained");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule